// File: doc/BRIEF.md
# Sixteen-Pin GPIO Expander Core with Change Interrupt

This block is the logic core of a sixteen-pin general-purpose I/O expander. The pins form two banks of eight, bank A on pad bits 7..0 and bank B on pad bits 15..8. Each pin has four per-pin settings: a direction bit, a polarity bit that inverts the value read back, an interrupt-enable bit, and an output latch. Every pad input passes through a two-flop synchronizer before it is read or compared.

A host reaches the registers through a plain single-cycle register port, such as a serial target controller would drive. A bank keeps a snapshot of its synchronized inputs, taken each time its input register is read. When an enabled input pin differs from that snapshot, the bank's pending flag is set. The flag stays set until the host reads that bank's input register. One configuration bit folds bank B's interrupt onto the bank A line. A second configuration bit selects the active level of both interrupt lines. By default the lines are active low.

Top module: `gpio_xpander`

## Requirements
- R1: The block has 16 pins in two banks: bank A uses pad bits 7..0, bank B uses pad bits 15..8. Even addresses select bank A and odd addresses select bank B. Address map: 0/1 direction, 2/3 polarity, 4/5 interrupt enable, 6/7 output latch, 8/9 input value, 10 configuration.
- R2: After reset every direction bit is 1 (input), so pad_oe is all 0. The output latch, polarity, interrupt-enable and configuration registers are all 0. Both interrupt lines sit at their inactive level, which is high.
- R3: A direction bit of 0 makes its pin an output, with pad_oe at 1 and pad_out equal to the latch bit. A direction bit of 1 keeps pad_oe at 0. pad_out always carries the latch.
- R4: Reading an input register returns the synchronized pad value XOR the bank's polarity bits, so a polarity bit of 1 inverts that pin.
- R5: A pin that is an input and has its interrupt enable set raises its bank's pending flag when its synchronized value differs from the snapshot. The interrupt line asserts on the third rising edge after the pad change.
- R6: A pending flag is sticky. It stays asserted after the pin returns to its old value, and it stays asserted through reads of other registers.
- R7: Reading bank A's input register (address 8) clears bank A's pending flag and re-takes its snapshot. Reading address 9 does the same for bank B. The line deasserts one cycle after the read.
- R8: A change on a pin whose interrupt enable is 0, or on a pin configured as an output, never raises the pending flag.
- R9: When configuration bit 0 (mirror) is 1, irq_a carries bank A's pending flag OR bank B's, and irq_b stays inactive. In this mode, reading address 8 clears both flags.
- R10: When configuration bit 1 is 1, both interrupt lines are active high: they sit low when idle and go high when pending.
- R11: Reads of unmapped addresses 11..15 return 0. Writes to the input registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read-clear side effect) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, same cycle |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| irq_a | output | 1 | Bank A interrupt line |
| irq_b | output | 1 | Bank B interrupt line |

## Verification
A wrong snapshot or pending flag shows up on irq_a or irq_b. It appears either three edges after a pad change, as a missing or spurious assertion, or one cycle after an input read, as a line that fails to clear. A wrong direction or latch bit shows up on pad_oe or pad_out on the cycle after the write. A wrong polarity bit shows up in the input-register read value. A mirror path that is wired wrong leaves irq_b active, or leaves irq_a set after the bank A read.

// File: rtl/gx_pkg.sv
package gx_pkg;
    parameter int BANK_W = 8;
    parameter int ADDR_W = 4;
    localparam int NBANK = 2;
    localparam int PIN_W = BANK_W * NBANK;

    typedef enum logic [2:0] {
        FLD_DIR  = 3'd0,
        FLD_POL  = 3'd1,
        FLD_IEN  = 3'd2,
        FLD_OUT  = 3'd3,
        FLD_IN   = 3'd4,
        FLD_CFG  = 3'd5,
        FLD_RSV6 = 3'd6,
        FLD_RSV7 = 3'd7
    } fld_e;

    typedef struct packed {
        logic irq_hi;
        logic mirror;
    } cfg_t;

    function automatic fld_e field_of(input logic [ADDR_W-1:0] a);
        return fld_e'(a[3:1]);
    endfunction

    function automatic logic irq_level(input logic pend, input logic hi);
        return hi ? pend : ~pend;
    endfunction
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gx_bank.sv
module gx_bank
    import gx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  fld_e         wr_fld,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_s,
    input  logic         rd_clr,
    output logic [W-1:0] dir,
    output logic [W-1:0] pol,
    output logic [W-1:0] ien,
    output logic [W-1:0] olat,
    output logic [W-1:0] in_val,
    output logic         pend
);
    logic [W-1:0] snap;
    logic [W-1:0] watch;
    logic [W-1:0] diff;

    assign watch  = ien & dir;
    assign diff   = (pin_s ^ snap) & watch;
    assign in_val = pin_s ^ pol;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir  <= '1;
            pol  <= '0;
            ien  <= '0;
            olat <= '0;
        end else if (wr_en) begin
            case (wr_fld)
                FLD_DIR: dir  <= wdata;
                FLD_POL: pol  <= wdata;
                FLD_IEN: ien  <= wdata;
                FLD_OUT: olat <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
            pend <= 1'b0;
        end else if (rd_clr) begin
            snap <= pin_s;
            pend <= 1'b0;
        end else begin
            snap <= (snap & watch) | (pin_s & ~watch);
            if (|diff) pend <= 1'b1;
        end
    end

    // R2: reset leaves every pin an input
    p_reset_dir_r2: assert property (@(posedge clk) rst |=> (dir == '1 && pend == 1'b0));

    // R5: an enabled input differing from the snapshot raises pending
    p_set_on_change_r5: assert property (@(posedge clk) disable iff (rst)
        ((|((pin_s ^ snap) & ien & dir)) && !rd_clr) |=> pend);

    // R6: pending holds until the read-clear
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (pend && !rd_clr) |=> pend);

    // R7: read-clear drops pending on the next cycle
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> !pend);
endmodule

// File: rtl/gx_irq_out.sv
module gx_irq_out
    import gx_pkg::*;
(
    input  logic pend_a,
    input  logic pend_b,
    input  cfg_t cfg,
    output logic irq_a,
    output logic irq_b
);
    logic line_a;
    logic line_b;

    always_comb begin
        if (cfg.mirror) begin
            line_a = pend_a | pend_b;
            line_b = 1'b0;
        end else begin
            line_a = pend_a;
            line_b = pend_b;
        end
    end

    assign irq_a = irq_level(line_a, cfg.irq_hi);
    assign irq_b = irq_level(line_b, cfg.irq_hi);
endmodule

// File: rtl/gpio_xpander.sv
module gpio_xpander
    import gx_pkg::*;
#(
    parameter int BW = gx_pkg::BANK_W,
    parameter int AW = gx_pkg::ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [AW-1:0]       reg_addr,
    input  logic [BW-1:0]       reg_wdata,
    output logic [BW-1:0]       reg_rdata,
    input  logic [2*BW-1:0]     pad_in,
    output logic [2*BW-1:0]     pad_out,
    output logic [2*BW-1:0]     pad_oe,
    output logic                irq_a,
    output logic                irq_b
);
    localparam int NB = 2;
    localparam int PW = NB * BW;

    fld_e          fld;
    logic          bsel;
    logic [PW-1:0] pin_s;
    logic [BW-1:0] dir_q  [NB];
    logic [BW-1:0] pol_q  [NB];
    logic [BW-1:0] ien_q  [NB];
    logic [BW-1:0] olat_q [NB];
    logic [BW-1:0] inv_q  [NB];
    logic [NB-1:0] pend;
    logic [NB-1:0] rd_in;
    logic [NB-1:0] rd_clr;
    cfg_t          cfg;

    assign fld  = field_of(reg_addr);
    assign bsel = reg_addr[0];

    gx_sync #(.W(PW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_s)
    );

    for (genvar gb = 0; gb < NB; gb++) begin : g_bank
        assign rd_in[gb] = reg_rd && (fld == FLD_IN) && (bsel == 1'(gb));

        gx_bank #(.W(BW)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (reg_wr && (bsel == 1'(gb))),
            .wr_fld (fld),
            .wdata  (reg_wdata),
            .pin_s  (pin_s[gb*BW +: BW]),
            .rd_clr (rd_clr[gb]),
            .dir    (dir_q[gb]),
            .pol    (pol_q[gb]),
            .ien    (ien_q[gb]),
            .olat   (olat_q[gb]),
            .in_val (inv_q[gb]),
            .pend   (pend[gb])
        );

        assign pad_out[gb*BW +: BW] = olat_q[gb];
        assign pad_oe[gb*BW +: BW]  = ~dir_q[gb];
    end

    assign rd_clr[0] = rd_in[0];
    assign rd_clr[1] = rd_in[1] | (rd_in[0] & cfg.mirror);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (reg_wr && fld == FLD_CFG && !bsel) begin
            cfg <= cfg_t'(reg_wdata[1:0]);
        end
    end

    always_comb begin
        case (fld)
            FLD_DIR: reg_rdata = dir_q[bsel];
            FLD_POL: reg_rdata = pol_q[bsel];
            FLD_IEN: reg_rdata = ien_q[bsel];
            FLD_OUT: reg_rdata = olat_q[bsel];
            FLD_IN:  reg_rdata = inv_q[bsel];
            FLD_CFG: reg_rdata = bsel ? '0 : {{(BW-2){1'b0}}, cfg};
            default: reg_rdata = '0;
        endcase
    end

    gx_irq_out u_irq (
        .pend_a (pend[0]),
        .pend_b (pend[1]),
        .cfg    (cfg),
        .irq_a  (irq_a),
        .irq_b  (irq_b)
    );

    // R9: in mirror mode a bank A input read leaves irq_a inactive next cycle
    p_mirror_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && fld == FLD_IN && !bsel && cfg.mirror) |=> (irq_a == !cfg.irq_hi));

    // R11: unmapped addresses read as zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr > AW'(10)) |-> (reg_rdata == '0));
endmodule

// File: tb/sim_gpio_xpander.sv
module sim_gpio_xpander;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic        irq_a;
    logic        irq_b;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    gpio_xpander u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    // {polarity, pad value, expected read} for bank A (R4)
    localparam logic [23:0] POL_TAB [6] = '{
        {8'h00, 8'h00, 8'h00},
        {8'hFF, 8'h00, 8'hFF},
        {8'h0F, 8'h33, 8'h3C},
        {8'hF0, 8'h81, 8'h71},
        {8'hAA, 8'hAA, 8'h00},
        {8'h00, 8'h5A, 8'h5A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pads(input logic [15:0] v);
        @(negedge clk);
        pad_in = v;
        cyc(4);
    endtask

    task automatic done;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        done();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R2: reset state
        chk("R2 pad_oe", pad_oe, 16'h0000);
        chk("R2 pad_out", pad_out, 16'h0000);
        chk("R2 irq_a idle high", irq_a, 1);
        chk("R2 irq_b idle high", irq_b, 1);
        rd(4'd0, rv); chk("R2 dir A", rv, 8'hFF);
        rd(4'd10, rv); chk("R2 cfg", rv, 8'h00);

        // R1 R3: direction and latch
        wr(4'd0, 8'h0F);
        wr(4'd6, 8'hA5);
        wr(4'd1, 8'h00);
        wr(4'd7, 8'h3C);
        cyc(1);
        chk("R3 oe A", pad_oe[7:0], 8'hF0);
        chk("R3 out A", pad_out[7:0], 8'hA5);
        chk("R1 oe B", pad_oe[15:8], 8'hFF);
        chk("R1 out B", pad_out[15:8], 8'h3C);
        wr(4'd1, 8'hFF);
        cyc(1);
        chk("R3 oe B input", pad_oe[15:8], 8'h00);

        // R4: polarity table
        for (int i = 0; i < 6; i++) begin
            wr(4'd2, POL_TAB[i][23:16]);
            pads({8'h00, POL_TAB[i][15:8]});
            rd(4'd8, rv);
            chk("R4 polarity read", rv, {24'h0, POL_TAB[i][7:0]});
        end

        // R5 R6 R7 R8 bank A
        wr(4'd0, 8'hFF);
        wr(4'd2, 8'h00);
        pads(16'h0000);
        rd(4'd8, rv);
        rd(4'd9, rv);
        wr(4'd4, 8'h01);
        pads(16'h0008);
        chk("R8 disabled pin no irq", irq_a, 1);
        pads(16'h0009);
        chk("R5 enabled change irq_a", irq_a, 0);
        pads(16'h0008);
        chk("R6 sticky after return", irq_a, 0);
        rd(4'd6, rv);
        chk("R6 sticky through other read", irq_a, 0);
        rd(4'd8, rv);
        chk("R7 read value", rv, 8'h08);
        chk("R7 irq_a cleared", irq_a, 1);
        wr(4'd0, 8'hFD);
        wr(4'd4, 8'h03);
        pads(16'h000A);
        chk("R8 output pin no irq", irq_a, 1);
        wr(4'd4, 8'h00);
        wr(4'd0, 8'hFF);

        // R5 R7 bank B
        wr(4'd5, 8'h80);
        pads(16'h800A);
        chk("R5 irq_b set", irq_b, 0);
        chk("R5 irq_a untouched", irq_a, 1);
        rd(4'd8, rv);
        chk("R7 A read keeps B", irq_b, 0);
        rd(4'd9, rv);
        chk("R7 B read value", rv, 8'h80);
        chk("R7 irq_b cleared", irq_b, 1);

        // R9 mirror
        wr(4'd10, 8'h01);
        pads(16'h000A);
        chk("R9 mirrored onto irq_a", irq_a, 0);
        chk("R9 irq_b quiet", irq_b, 1);
        rd(4'd8, rv);
        chk("R9 A read clears both", irq_a, 1);
        wr(4'd10, 8'h00);
        cyc(1);
        chk("R9 B pending cleared", irq_b, 1);

        // R10 active high
        wr(4'd10, 8'h02);
        cyc(1);
        chk("R10 idle low a", irq_a, 0);
        chk("R10 idle low b", irq_b, 0);
        wr(4'd4, 8'h01);
        pads(16'h000B);
        chk("R10 asserted high", irq_a, 1);

        // R11 unmapped and input write
        rd(4'd15, rv);
        chk("R11 unmapped zero", rv, 8'h00);
        wr(4'd8, 8'hFF);
        rd(4'd8, rv);
        chk("R11 input write ignored", rv, 8'h0B);
        wr(4'd3, 8'h5C);
        rd(4'd3, rv);
        chk("R1 pol B readback", rv, 8'h5C);

        done();
    end
endmodule